// File: doc/BRIEF.md
# Bitplane Screen Column Address Generator

This block turns a compact screen configuration into the byte addresses that a pixel engine needs to reach a tile-organised bitplane frame buffer. The frame buffer is laid out as 32 character columns, each eight pixels wide. Inside a column, tiles are stacked one row after another. The block takes three inputs: an 8-bit screen base register, a 6-bit screen mode field that carries the colour depth and the height select, and an object-drawing flag. From these it produces four outputs: the buffer size, a screen base that is pulled down so the whole buffer fits in the installed RAM, the number of bytes in one tile, and the start address of any column 0 to 31 that the user asks for.

The column stride does not have to be a power of two. At 160 and 192 lines it is 20 or 24 tiles tall. At 256 lines, and whenever the object flag is set, the buffer uses a split layout: the top bit of the column index picks one of two halves of the buffer, and the remaining four bits step through the columns inside that half. Screen settings are captured into a held configuration. That configuration is recomputed only when the depth, the height select or the object flag changes, or when a base-write strobe has flagged the base register as changed. A new base value with no strobe and no other change is not used.

Top module: `bpcol_addr_gen`

## Requirements
- R1: The screen base output equals the base register times 1024 whenever that base plus the buffer size fits in RAM.
- R2: Colour depth is scr_mode_i[1:0]. The height select is {scr_mode_i[5], scr_mode_i[2]}, and its codes 0, 1, 2 and 3 mean 128, 160, 192 and 256 lines. Bits 4:3 have no effect on any output.
- R3: For height codes 0 to 2 with the object flag clear, column i starts at base + i × (lines/8) × tile_bytes. tile_bytes is 16, 32, 64 or 64 for depth 0, 1, 2 or 3.
- R4: In the split layout, column i starts at base + (i[4] << (13+m)) + (i[3:0] << (8+m)), where m is 0, 1 or 2 for depth 0, 1 or 2/3.
- R5: For height codes 0 to 2, the size is (lines/8) × 32 × k, with k equal to 16, 32, 32 or 64 for depth 0 to 3. For code 3 the size is 32768.
- R6: A set object flag selects the split layout whatever the height code is, but the size is still taken from the height code.
- R7: If base register × 1024 + size is larger than RAM_BANKS × 65536, the base output becomes RAM_BANKS × 65536 − size.
- R8: The held configuration is recomputed only when depth, height select or object flag differ from the held values, or when the base is flagged as changed. A new base register value with none of these leaves every output unchanged.
- R9: A base_wr_i pulse flags the base as changed at the next edge. The edge after that recomputes and clears the flag. If a strobe falls on an edge that recomputes, the flag stays set, so the following edge recomputes once more.
- R10: While reset is held, the outputs show depth 0 and height code 0 at base 0: size 8192, tile bytes 16, and column i at i × 256. A recompute is pending for the first edge after reset.
- R11: tile_bytes_o shows the bytes per tile for the held depth: 16, 32, 64 or 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scr_mode_i | input | 6 | Screen mode: depth in [1:0], height select in bits 5 and 2 |
| obj_mode_i | input | 1 | Object-drawing flag, forces the split layout |
| base_reg_i | input | 8 | Screen base register, in 1 KB units |
| base_wr_i | input | 1 | Strobe that flags the base register as changed |
| col_i | input | COL_W | Column index to look up |
| base_o | output | ADDR_W | Screen base after clamping |
| size_o | output | SIZE_W | Frame-buffer size in bytes |
| tile_bytes_o | output | 7 | Bytes per tile at the held depth |
| col_addr_o | output | ADDR_W | Start address of column col_i |

## Verification
Two functions can act on the same edge: a recompute caused by a mode change, and a base-write strobe that must leave the changed-base flag set. The bench provokes this by changing the depth, the base register and the strobe at the same negative edge. It checks that the new base appears after that edge. It then changes the base register again without a strobe and checks that the following edge picks up this second value as well, which shows the flag survived the overlapping recompute. A sweep over every depth, height select, object flag and a set of base values, including values that force clamping, compares all 32 column addresses and the size against values worked out by arithmetic.

// File: rtl/bpcol_pkg.sv
package bpcol_pkg;

    typedef struct packed {
        logic [1:0] depth;
        logic [1:0] hsel;
        logic       obj;
    } view_t;

    // log2 of tile bytes divided by 16
    function automatic logic [1:0] depth_log(input logic [1:0] depth);
        logic [1:0] r;
        case (depth)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

    function automatic view_t decode_view(input logic [5:0] scr_mode, input logic obj);
        view_t v;
        v.depth = scr_mode[1:0];
        v.hsel  = {scr_mode[5], scr_mode[2]};
        v.obj   = obj;
        return v;
    endfunction

endpackage

// File: rtl/bpcol_size.sv
module bpcol_size #(
    parameter int SIZE_W = 16
) (
    input  logic [1:0]        depth_i,
    input  logic [1:0]        hsel_i,
    output logic [SIZE_W-1:0] size_o
);
    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(32768);

    logic [SIZE_W-1:0] rows;
    logic [3:0]        sh;

    always_comb begin
        rows = SIZE_W'(16) + (SIZE_W'(hsel_i) << 2);
        case (depth_i)
            2'd0:    sh = 4'd9;
            2'd3:    sh = 4'd11;
            default: sh = 4'd10;
        endcase
        if (hsel_i == 2'd3) size_o = FULL_SIZE;
        else                size_o = rows << sh;
    end
endmodule

// File: rtl/bpcol_clamp.sv
module bpcol_clamp #(
    parameter int ADDR_W    = 19,
    parameter int SIZE_W    = 16,
    parameter int RAM_BANKS = 2
) (
    input  logic [7:0]        base_reg_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] base_o
);
    localparam logic [ADDR_W-1:0] RAM_BYTES = ADDR_W'(RAM_BANKS * 65536);

    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] top;

    always_comb begin
        raw = ADDR_W'(base_reg_i) << 10;
        top = raw + ADDR_W'(size_i);
        if (top > RAM_BYTES) base_o = RAM_BYTES - ADDR_W'(size_i);
        else                 base_o = raw;
    end
endmodule

// File: rtl/bpcol_offset.sv
module bpcol_offset #(
    parameter int ADDR_W = 19,
    parameter int COL_W  = 5
) (
    input  logic [COL_W-1:0]  col_i,
    input  logic [1:0]        depth_i,
    input  logic [1:0]        hsel_i,
    output logic [ADDR_W-1:0] off_o
);
    import bpcol_pkg::*;

    localparam int LO_W = COL_W - 1;

    logic [1:0]        m;
    logic [ADDR_W-1:0] rows;
    logic [ADDR_W-1:0] hi_part;
    logic [ADDR_W-1:0] lo_part;
    logic [ADDR_W-1:0] linear;

    generate
        if (LO_W > 0) begin : g_split
            always_comb begin
                hi_part = ADDR_W'(col_i[COL_W-1]) << (13 + int'(m));
                lo_part = ADDR_W'(col_i[LO_W-1:0]) << (8 + int'(m));
            end
        end else begin : g_flat
            always_comb begin
                hi_part = ADDR_W'(col_i) << (13 + int'(m));
                lo_part = '0;
            end
        end
    endgenerate

    always_comb begin
        m      = depth_log(depth_i);
        rows   = ADDR_W'(16) + (ADDR_W'(hsel_i) << 2);
        linear = (ADDR_W'(col_i) * rows) << (4 + int'(m));
        if (hsel_i == 2'd3) off_o = hi_part + lo_part;
        else                off_o = linear;
    end
endmodule

// File: rtl/bpcol_tracker.sv
module bpcol_tracker #(
    parameter int ADDR_W = 19,
    parameter int SIZE_W = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  bpcol_pkg::view_t      view_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [SIZE_W-1:0]     size_i,
    input  logic                  mark_i,
    output bpcol_pkg::view_t      view_o,
    output logic [ADDR_W-1:0]     base_o,
    output logic [SIZE_W-1:0]     size_o
);
    import bpcol_pkg::*;

    typedef struct packed {
        view_t             view;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              dirty;
    } state_t;

    state_t st_d, st_q;
    logic   refresh;

    always_comb begin
        st_d    = st_q;
        refresh = st_q.dirty || (view_i != st_q.view);
        if (refresh) begin
            st_d.view  = view_i;
            st_d.base  = base_i;
            st_d.size  = size_i;
            st_d.dirty = 1'b0;
        end
        if (mark_i) st_d.dirty = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.view  <= '0;
            st_q.base  <= '0;
            st_q.size  <= SIZE_W'(8192);
            st_q.dirty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign view_o = st_q.view;
    assign base_o = st_q.base;
    assign size_o = st_q.size;

    // R8: no change and no flag keeps the held base
    a_r8_base_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.dirty && !mark_i && view_i == st_q.view) |=> $stable(base_o));

    // R9: strobe always leaves the flag set
    a_r9_mark_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mark_i |=> st_q.dirty);

    // R9: a flagged recompute without a new strobe clears the flag
    a_r9_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.dirty && !mark_i) |=> !st_q.dirty);
endmodule

// File: rtl/bpcol_addr_gen.sv
module bpcol_addr_gen #(
    parameter int RAM_BANKS = 2,
    parameter int COL_W     = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [5:0]       scr_mode_i,
    input  logic             obj_mode_i,
    input  logic [7:0]       base_reg_i,
    input  logic             base_wr_i,
    input  logic [COL_W-1:0] col_i,
    output logic [((16 + $clog2(RAM_BANKS)) > 18 ? (16 + $clog2(RAM_BANKS)) : 18):0] base_o,
    output logic [15:0]      size_o,
    output logic [6:0]       tile_bytes_o,
    output logic [((16 + $clog2(RAM_BANKS)) > 18 ? (16 + $clog2(RAM_BANKS)) : 18):0] col_addr_o
);
    import bpcol_pkg::*;

    localparam int RAM_W  = 16 + $clog2(RAM_BANKS);
    localparam int ADDR_W = (RAM_W > 18 ? RAM_W : 18) + 1;
    localparam int SIZE_W = 16;
    localparam logic [ADDR_W:0] RAM_BYTES = (ADDR_W+1)'(RAM_BANKS * 65536);

    view_t             in_view, held_view;
    logic [SIZE_W-1:0] new_size;
    logic [ADDR_W-1:0] new_base;
    logic [ADDR_W-1:0] off;
    logic [1:0]        addr_hsel;

    assign in_view = decode_view(scr_mode_i, obj_mode_i);

    bpcol_size #(.SIZE_W(SIZE_W)) size_i (
        .depth_i (in_view.depth),
        .hsel_i  (in_view.hsel),
        .size_o  (new_size)
    );

    bpcol_clamp #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .RAM_BANKS(RAM_BANKS)) clamp_i (
        .base_reg_i (base_reg_i),
        .size_i     (new_size),
        .base_o     (new_base)
    );

    bpcol_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) track_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .view_i (in_view),
        .base_i (new_base),
        .size_i (new_size),
        .mark_i (base_wr_i),
        .view_o (held_view),
        .base_o (base_o),
        .size_o (size_o)
    );

    assign addr_hsel = held_view.obj ? 2'd3 : held_view.hsel;

    bpcol_offset #(.ADDR_W(ADDR_W), .COL_W(COL_W)) off_i (
        .col_i   (col_i),
        .depth_i (held_view.depth),
        .hsel_i  (addr_hsel),
        .off_o   (off)
    );

    assign col_addr_o   = base_o + off;
    assign tile_bytes_o = 7'(16) << depth_log(held_view.depth);

    // R7: the held buffer never runs past installed RAM
    a_r7_fits_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, base_o} + (ADDR_W+1)'(size_o)) <= RAM_BYTES);

    // R1: base stays on a 1 KB boundary, clamped or not
    a_r1_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_o[9:0] == 10'd0);
endmodule

// File: tb/bpcol_addr_gen_tb.sv
module bpcol_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAM_BANKS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  scr_mode = '0;
    logic        obj = 1'b0;
    logic [7:0]  base_reg = '0;
    logic        base_wr = 1'b0;
    logic [4:0]  col = '0;
    logic [18:0] base_o, col_addr;
    logic [15:0] size_o;
    logic [6:0]  tile_bytes;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpcol_addr_gen #(.RAM_BANKS(RAM_BANKS), .COL_W(5)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scr_mode_i(scr_mode), .obj_mode_i(obj),
        .base_reg_i(base_reg), .base_wr_i(base_wr), .col_i(col),
        .base_o(base_o), .size_o(size_o), .tile_bytes_o(tile_bytes), .col_addr_o(col_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_size(input int d, input int h);
        int k;
        if (h == 3) return 32768;
        k = (d == 0) ? 16 : (d == 3) ? 64 : 32;
        return ((128 + 32*h) / 8) * 32 * k;
    endfunction

    function automatic int exp_base(input int r, input int d, input int h);
        int b = r * 1024;
        int s = exp_size(d, h);
        if (b + s > RAM_BANKS * 65536) b = RAM_BANKS * 65536 - s;
        return b;
    endfunction

    function automatic int exp_tb(input int d);
        return (d == 0) ? 16 : (d == 1) ? 32 : 64;
    endfunction

    function automatic int exp_off(input int i, input int d, input int h, input int o);
        int eh = o ? 3 : h;
        int m  = (d == 0) ? 0 : (d == 1) ? 1 : 2;
        if (eh == 3) return (((i / 16) * 8192) << m) + (((i % 16) * 256) << m);
        return i * ((128 + 32*eh) / 8) * exp_tb(d);
    endfunction

    function automatic logic [5:0] mk_mode(input int d, input int h, input int junk);
        logic [5:0] v;
        v[1:0] = 2'(d);
        v[2]   = h[0];
        v[4:3] = 2'(junk);
        v[5]   = h[1];
        return v;
    endfunction

    task automatic check_cols(input int d, input int h, input int o, input int r);
        int b = exp_base(r, d, h);
        for (int i = 0; i < 32; i++) begin
            col = 5'(i);
            #1;
            if ((o != 0) || (h == 3)) chk("R4 split column", int'(col_addr), b + exp_off(i, d, h, o));
            else                      chk("R3 linear column", int'(col_addr), b + exp_off(i, d, h, o));
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int bases[4] = '{0, 16, 127, 255};
        // R10: reset state
        #(CLK_PERIOD*2 + 1);
        chk("R10 reset base", int'(base_o), 0);
        chk("R10 reset size", int'(size_o), 8192);
        chk("R10 reset tile bytes", int'(tile_bytes), 16);
        col = 5'd7; #1;
        chk("R10 reset column", int'(col_addr), 7*256);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep: R1 R2 R3 R4 R5 R6 R7 R11
        for (int d = 0; d < 4; d++)
            for (int h = 0; h < 4; h++)
                for (int o = 0; o < 2; o++)
                    for (int bi = 0; bi < 4; bi++) begin
                        @(negedge clk);
                        scr_mode = mk_mode(d, h, d + bi);
                        obj      = o[0];
                        base_reg = 8'(bases[bi]);
                        base_wr  = 1'b1;
                        @(negedge clk);
                        base_wr  = 1'b0;
                        @(negedge clk);
                        #1;
                        if (bases[bi] * 1024 + exp_size(d, h) > RAM_BANKS * 65536)
                            chk("R7 clamped base", int'(base_o), exp_base(bases[bi], d, h));
                        else
                            chk("R1 base scaling", int'(base_o), bases[bi] * 1024);
                        if (o != 0) chk("R6 size from code", int'(size_o), exp_size(d, h));
                        else        chk("R5 size", int'(size_o), exp_size(d, h));
                        chk("R11 tile bytes", int'(tile_bytes), exp_tb(d));
                        check_cols(d, h, o, bases[bi]);
                    end

        // R2: bits 4:3 alone change nothing
        @(negedge clk);
        scr_mode = mk_mode(1, 2, 0); obj = 1'b0; base_reg = 8'd5; base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        @(negedge clk);
        scr_mode = mk_mode(1, 2, 3); base_reg = 8'd9;
        @(negedge clk); @(negedge clk); #1;
        chk("R2 ignored mode bits base", int'(base_o), 5*1024);
        chk("R2 height select 192", int'(size_o), exp_size(1, 2));

        // R9: strobe on the same edge as a mode-change recompute
        @(negedge clk);
        scr_mode = mk_mode(0, 2, 3); base_reg = 8'd6; base_wr = 1'b1;
        @(negedge clk); #1;
        chk("R9 overlap first recompute", int'(base_o), 6*1024);
        base_wr = 1'b0; base_reg = 8'd7;
        @(negedge clk); #1;
        chk("R9 flag survived overlap", int'(base_o), 7*1024);

        // R8: base change alone ignored, then picked up by a height change
        base_reg = 8'd8;
        @(negedge clk); @(negedge clk); @(negedge clk); #1;
        chk("R8 base ignored without strobe", int'(base_o), 7*1024);
        col = 5'd3; #1;
        chk("R8 column unchanged", int'(col_addr), 7*1024 + 3*24*16);
        scr_mode = mk_mode(0, 1, 3);
        @(negedge clk); #1;
        chk("R8 height change recomputes", int'(base_o), 8*1024);
        chk("R8 new height size", int'(size_o), exp_size(0, 1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule